// File: doc/BRIEF.md
# Buffered Configuration Port Controller

This block sits between a 32-bit register bus and a device configuration port. Software fills an outbound FIFO with configuration words. A command bit then makes the controller stream those words to the port through a valid/ready sink interface. For readback, software writes a word count and issues a second command bit. The controller then pulls exactly that many words from the port's source interface into an inbound FIFO, which software drains through a data register.

Both FIFO levels can be read by software as registers. The outbound level is reported as free space and the inbound level as a word count, so a driver can move blocks of words without polling per word. A status register reports whether a transfer is running. It also passes through three condition lines from the configuration port: error and abort, both active low, and word alignment. A control write can flush both FIFOs, or can return the whole controller to its reset state.

Register reads are registered: the data for a read request appears on `reg_rdata` in the next cycle.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the status register reads done=1, the vacancy register reads WR_DEPTH, occupancy and size read 0, and `cfg_out_valid` and `cfg_in_ready` are low.
- R2: Register offsets are: 0x100 outbound data (write), 0x104 inbound data (read), 0x108 readback size, 0x10C control, 0x110 status, 0x114 vacancy and 0x118 occupancy. The size register keeps only bits 11:0, so the largest count is 0xFFF. The control register and unmapped offsets read 0.
- R3: Writing control bit 0 while idle streams the outbound FIFO to the port in write order. Done (status bit 0) is 0 until the FIFO is empty and then returns to 1.
- R4: A write to offset 0x100 while the outbound FIFO holds WR_DEPTH words is dropped.
- R5: Writing control bit 1 while idle with a non-zero size collects exactly that many words from the port, in arrival order. Done then returns to 1. With size 0 the command does nothing.
- R6: A read of offset 0x104 while the inbound FIFO is empty returns 0 and leaves the occupancy unchanged.
- R7: `cfg_in_ready` is low whenever the inbound FIFO is full. No port word is lost while software drains it.
- R8: Start commands (control bits 0 and 1) are ignored while done is 0.
- R9: Control bit 2 empties both FIFOs and leaves the size register unchanged.
- R10: Control bit 3 returns the controller to its reset state: it stops a running transfer, empties both FIFOs and clears the size register.
- R11: Status bits: 0 done, 5 abort input (active low), 6 readback running, 7 alignment input, 8 error input (active low). All other bits are 0. Done is never 1 while a transfer runs.
- R12: Vacancy reads WR_DEPTH minus the outbound count and occupancy reads the inbound count. A read issued in the cycle after a push or pop sees the new level.
- R13: Read data appears on `reg_rdata` in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_en | input | 1 | Register access request for this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| cfg_out_valid | output | 1 | Outbound word available to the port |
| cfg_out_ready | input | 1 | Port accepts the outbound word |
| cfg_out_data | output | 32 | Outbound configuration word |
| cfg_in_valid | input | 1 | Port offers a readback word |
| cfg_in_ready | output | 1 | Controller accepts the readback word |
| cfg_in_data | input | 32 | Readback word |
| cfg_err_n | input | 1 | Port error condition, active low |
| cfg_aligned | input | 1 | Port word alignment condition |
| cfg_abort_n | input | 1 | Port abort condition, active low |

## Verification
The bench builds the controller with WR_DEPTH=8 and RD_DEPTH=4 in place of 1024 and 256. At these depths, overfilling the outbound FIFO and holding the port source back on a full inbound FIFO each take only a few register accesses. A six-word readback into the four-word inbound FIFO exercises stall and resume in one run. The size register keeps its full 12-bit width, so the truncation at 0xFFF is checked at its real boundary.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int unsigned OFF_WFIFO = 'h100;
  localparam int unsigned OFF_RFIFO = 'h104;
  localparam int unsigned OFF_SIZE  = 'h108;
  localparam int unsigned OFF_CTRL  = 'h10C;
  localparam int unsigned OFF_STAT  = 'h110;
  localparam int unsigned OFF_VAC   = 'h114;
  localparam int unsigned OFF_OCC   = 'h118;

  localparam int unsigned CB_START_WR = 0;
  localparam int unsigned CB_START_RD = 1;
  localparam int unsigned CB_FLUSH    = 2;
  localparam int unsigned CB_SOFTRST  = 3;

  localparam int unsigned SB_DONE    = 0;
  localparam int unsigned SB_ABORT_N = 5;
  localparam int unsigned SB_RB_RUN  = 6;
  localparam int unsigned SB_ALIGN   = 7;
  localparam int unsigned SB_ERR_N   = 8;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_WRITE = 2'd1,
    XS_READ  = 2'd2
  } xfer_state_e;

endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (clr) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (push_ok) wptr_n = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_n = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wptr_q] <= push_data;
  end

endmodule

// File: rtl/cfgp_xfer.sv
module cfgp_xfer
  import cfgport_pkg::*;
#(
  parameter int unsigned SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [SIZE_W-1:0] size,
  input  logic              wf_empty,
  input  logic              rf_full,
  input  logic              cfg_out_ready,
  input  logic              cfg_in_valid,
  output logic              cfg_out_valid,
  output logic              cfg_in_ready,
  output logic              wf_pop,
  output logic              rf_push,
  output logic              done,
  output logic              wr_active,
  output logic              rb_active
);

  xfer_state_e       state_q, state_n;
  logic [SIZE_W-1:0] remain_q, remain_n;
  logic              wr_go, rd_go;

  assign done      = (state_q == XS_IDLE);
  assign wr_active = (state_q == XS_WRITE);
  assign rb_active = (state_q == XS_READ);

  assign wr_go = done && start_wr;
  assign rd_go = done && start_rd && !start_wr && (size != '0);

  assign cfg_out_valid = wr_active && !wf_empty;
  assign wf_pop        = cfg_out_valid && cfg_out_ready;
  assign cfg_in_ready  = rb_active && !rf_full && (remain_q != '0);
  assign rf_push       = cfg_in_ready && cfg_in_valid;

  always_comb begin
    state_n  = state_q;
    remain_n = remain_q;
    if (clr) begin
      state_n  = XS_IDLE;
      remain_n = '0;
    end else begin
      case (state_q)
        XS_IDLE: begin
          if (wr_go) begin
            state_n = XS_WRITE;
          end else if (rd_go) begin
            state_n  = XS_READ;
            remain_n = size;
          end
        end
        XS_WRITE: begin
          if (wf_empty) state_n = XS_IDLE;
        end
        XS_READ: begin
          if (rf_push) remain_n = remain_q - 1'b1;
          if (remain_n == '0) state_n = XS_IDLE;
        end
        default: state_n = XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= XS_IDLE;
      remain_q <= '0;
    end else begin
      state_q  <= state_n;
      remain_q <= remain_n;
    end
  end

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int unsigned WR_DEPTH = 1024,
  parameter int unsigned RD_DEPTH = 256,
  parameter int unsigned SIZE_W   = 12,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cfg_out_valid,
  input  logic              cfg_out_ready,
  output logic [31:0]       cfg_out_data,
  input  logic              cfg_in_valid,
  output logic              cfg_in_ready,
  input  logic [31:0]       cfg_in_data,
  input  logic              cfg_err_n,
  input  logic              cfg_aligned,
  input  logic              cfg_abort_n
);

  localparam int unsigned WCW = $clog2(WR_DEPTH + 1);
  localparam int unsigned RCW = $clog2(RD_DEPTH + 1);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [SIZE_W-1:0] size_q, size_n;
  logic [31:0]       rdata_q, rdata_n;
  logic              rd_req, wr_req;
  logic              ctrl_wr, soft_rst, fifo_clr, start_wr, start_rd;
  logic              wf_push_req, rf_pop_req;
  logic              wf_pop, rf_push, wf_full, wf_empty, rf_full, rf_empty;
  logic [31:0]       rf_head;
  logic [WCW-1:0]    wf_cnt;
  logic [RCW-1:0]    rf_cnt;
  logic              done, wr_active, rb_active;
  logic [31:0]       status_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign wr_req      = reg_en && reg_wr;
  assign rd_req      = reg_en && !reg_wr;
  assign ctrl_wr     = wr_req && (reg_addr == ADDR_W'(OFF_CTRL));
  assign soft_rst    = ctrl_wr && reg_wdata[CB_SOFTRST];
  assign fifo_clr    = ctrl_wr && (reg_wdata[CB_FLUSH] || reg_wdata[CB_SOFTRST]);
  assign start_wr    = ctrl_wr && reg_wdata[CB_START_WR];
  assign start_rd    = ctrl_wr && reg_wdata[CB_START_RD];
  assign wf_push_req = wr_req && (reg_addr == ADDR_W'(OFF_WFIFO));
  assign rf_pop_req  = rd_req && (reg_addr == ADDR_W'(OFF_RFIFO));

  cfgp_fifo #(.DEPTH(WR_DEPTH), .WIDTH(32)) u_wfifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (fifo_clr),
    .push      (wf_push_req),
    .push_data (reg_wdata),
    .pop       (wf_pop),
    .head      (cfg_out_data),
    .count     (wf_cnt),
    .full      (wf_full),
    .empty     (wf_empty)
  );

  cfgp_fifo #(.DEPTH(RD_DEPTH), .WIDTH(32)) u_rfifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (fifo_clr),
    .push      (rf_push),
    .push_data (cfg_in_data),
    .pop       (rf_pop_req),
    .head      (rf_head),
    .count     (rf_cnt),
    .full      (rf_full),
    .empty     (rf_empty)
  );

  cfgp_xfer #(.SIZE_W(SIZE_W)) u_xfer (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .clr           (soft_rst),
    .start_wr      (start_wr),
    .start_rd      (start_rd),
    .size          (size_q),
    .wf_empty      (wf_empty),
    .rf_full       (rf_full),
    .cfg_out_ready (cfg_out_ready),
    .cfg_in_valid  (cfg_in_valid),
    .cfg_out_valid (cfg_out_valid),
    .cfg_in_ready  (cfg_in_ready),
    .wf_pop        (wf_pop),
    .rf_push       (rf_push),
    .done          (done),
    .wr_active     (wr_active),
    .rb_active     (rb_active)
  );

  always_comb begin
    status_word             = '0;
    status_word[SB_DONE]    = done;
    status_word[SB_ABORT_N] = cfg_abort_n;
    status_word[SB_RB_RUN]  = rb_active;
    status_word[SB_ALIGN]   = cfg_aligned;
    status_word[SB_ERR_N]   = cfg_err_n;
  end

  always_comb begin
    size_n = size_q;
    if (soft_rst) size_n = '0;
    else if (wr_req && (reg_addr == ADDR_W'(OFF_SIZE))) size_n = reg_wdata[SIZE_W-1:0];
  end

  always_comb begin
    rdata_n = '0;
    case (reg_addr)
      ADDR_W'(OFF_RFIFO): rdata_n = rf_empty ? '0 : rf_head;
      ADDR_W'(OFF_SIZE):  rdata_n = 32'(size_q);
      ADDR_W'(OFF_STAT):  rdata_n = status_word;
      ADDR_W'(OFF_VAC):   rdata_n = 32'(WR_DEPTH) - 32'(wf_cnt);
      ADDR_W'(OFF_OCC):   rdata_n = 32'(rf_cnt);
      default:            rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      size_q  <= '0;
      rdata_q <= '0;
    end else begin
      size_q <= size_n;
      if (rd_req) rdata_q <= rdata_n;
    end
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/cfgport_ctrl_chk.sv
module cfgport_ctrl_chk #(
  parameter int unsigned WR_DEPTH = 1024,
  parameter int unsigned RD_DEPTH = 256,
  localparam int unsigned WCW = $clog2(WR_DEPTH + 1),
  localparam int unsigned RCW = $clog2(RD_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_out_valid,
  input logic           cfg_in_ready,
  input logic [WCW-1:0] wf_cnt,
  input logic [RCW-1:0] rf_cnt,
  input logic           wf_push_req,
  input logic           wf_full,
  input logic           wf_pop,
  input logic           fifo_clr,
  input logic           done,
  input logic           wr_active,
  input logic           rb_active
);

  // R7
  rf_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_in_ready |-> (rf_cnt < RCW'(RD_DEPTH)));

  // R4
  wf_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wf_cnt <= WCW'(WR_DEPTH));

  // R3
  out_valid_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out_valid |-> (wr_active && (wf_cnt != '0)));

  // R5
  in_ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_in_ready |-> rb_active);

  // R12
  wf_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_push_req && !wf_full && !wf_pop && !fifo_clr) |=> (wf_cnt == $past(wf_cnt) + 1'b1));

  // R11
  done_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(wr_active || rb_active));

endmodule

bind cfgport_ctrl cfgport_ctrl_chk #(.WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cfg_out_valid (cfg_out_valid),
  .cfg_in_ready  (cfg_in_ready),
  .wf_cnt        (wf_cnt),
  .rf_cnt        (rf_cnt),
  .wf_push_req   (wf_push_req),
  .wf_full       (wf_full),
  .wf_pop        (wf_pop),
  .fifo_clr      (fifo_clr),
  .done          (done),
  .wr_active     (wr_active),
  .rb_active     (rb_active)
);

// File: tb/cfgport_ctrl_tb.sv
module cfgport_ctrl_tb;

  localparam int unsigned WD = 8;
  localparam int unsigned RD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cfg_out_valid;
  logic        cfg_out_ready = 1'b0;
  logic [31:0] cfg_out_data;
  logic        cfg_in_valid = 1'b0;
  logic        cfg_in_ready;
  logic [31:0] cfg_in_data = '0;
  logic        cfg_err_n = 1'b1;
  logic        cfg_aligned = 1'b0;
  logic        cfg_abort_n = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // port models
  int          sink_mode = 0;   // 0 never ready, 1 always, 2 alternate
  bit          sink_tgl = 0;
  bit          src_en = 0;
  bit          src_take = 0;
  logic [31:0] src_word = 32'h5000_0000;
  logic [31:0] cap [64];
  int          cap_n = 0;

  always #4 clk = ~clk;

  cfgport_ctrl #(.WR_DEPTH(WD), .RD_DEPTH(RD), .SIZE_W(12), .ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_out_valid(cfg_out_valid),
    .cfg_out_ready(cfg_out_ready), .cfg_out_data(cfg_out_data), .cfg_in_valid(cfg_in_valid),
    .cfg_in_ready(cfg_in_ready), .cfg_in_data(cfg_in_data), .cfg_err_n(cfg_err_n),
    .cfg_aligned(cfg_aligned), .cfg_abort_n(cfg_abort_n)
  );

  always @(negedge clk) begin
    if (src_take) src_word = src_word + 1;
    cfg_in_valid = src_en;
    cfg_in_data  = src_word;
    src_take     = cfg_in_valid && cfg_in_ready;
    cfg_out_ready = (sink_mode == 1) || (sink_mode == 2 && sink_tgl);
    sink_tgl = ~sink_tgl;
    if (cfg_out_valid && cfg_out_ready && cap_n < 64) begin
      cap[cap_n] = cfg_out_data;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // callers start at a negedge; each access takes one cycle
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_en = 1; reg_wr = 0; reg_addr = a;
    @(negedge clk);
    reg_en = 0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read and compare, 2 idle cycles
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 12'h110, 32'h0,         32'h121},  // R1 R11 idle status
    '{2'd1, 12'h114, 32'h0,         32'h8},    // R1 R12 vacancy
    '{2'd1, 12'h118, 32'h0,         32'h0},    // R1 R12 occupancy
    '{2'd0, 12'h108, 32'h5,         32'h0},
    '{2'd1, 12'h108, 32'h0,         32'h5},    // R2 size
    '{2'd0, 12'h108, 32'h0001_2FFF, 32'h0},
    '{2'd1, 12'h108, 32'h0,         32'hFFF},  // R2 size truncated
    '{2'd0, 12'h100, 32'hA1,        32'h0},
    '{2'd0, 12'h100, 32'hA2,        32'h0},
    '{2'd0, 12'h100, 32'hA3,        32'h0},
    '{2'd1, 12'h114, 32'h0,         32'h5},    // R12 vacancy after 3 pushes
    '{2'd1, 12'h10C, 32'h0,         32'h0},    // R2 control reads 0
    '{2'd0, 12'h10C, 32'h1,         32'h0},
    '{2'd1, 12'h110, 32'h0,         32'h120},  // R3 busy during drain
    '{2'd2, 12'h000, 32'd8,         32'h0},
    '{2'd1, 12'h114, 32'h0,         32'h8},    // R3 drained
    '{2'd1, 12'h110, 32'h0,         32'h121}   // R3 done again
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] nexp;
    int base;
    nexp = 32'h5000_0000;

    idle(3);
    rst_n = 1;
    idle(4);
    chk("R1 out_valid after reset", {31'b0, cfg_out_valid}, 32'h0);
    chk("R1 in_ready after reset", {31'b0, cfg_in_ready}, 32'h0);
    rd(12'h108, d); chk("R1 size after reset", d, 32'h0);
    rd(12'h104, d); chk("R13 R6 empty inbound read", d, 32'h0);

    sink_mode = 1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: begin
          rd(VEC[i].addr, d);
          total++;
          if (d !== VEC[i].exp) begin
            bad++;
            $display("FAIL table row %0d addr=%h got=%h exp=%h", i, VEC[i].addr, d, VEC[i].exp);
          end
        end
        default: idle(int'(VEC[i].data));
      endcase
    end
    chk("R3 word count", cap_n, 3);
    chk("R3 order 0", cap[0], 32'hA1);
    chk("R3 order 1", cap[1], 32'hA2);
    chk("R3 order 2", cap[2], 32'hA3);

    // R4 overfill outbound FIFO, drain with alternating ready
    sink_mode = 2;
    for (int i = 0; i < 10; i++) wr(12'h100, 32'hB0 + i);
    rd(12'h114, d); chk("R4 vacancy at full", d, 32'h0);
    base = cap_n;
    wr(12'h10C, 32'h1);
    idle(30);
    chk("R4 drained count", cap_n - base, 8);
    for (int i = 0; i < 8; i++) chk("R4 drained word", cap[base + i], 32'hB0 + i);
    rd(12'h110, d); chk("R3 done after drain", d, 32'h121);

    // R8 start ignored while busy
    sink_mode = 0;
    src_en = 1;
    wr(12'h100, 32'hC0);
    wr(12'h100, 32'hC1);
    wr(12'h10C, 32'h1);
    wr(12'h108, 32'h2);
    wr(12'h10C, 32'h2);
    idle(6);
    rd(12'h118, d); chk("R8 readback ignored occ", d, 32'h0);
    rd(12'h110, d); chk("R8 status busy no readback", d, 32'h120);
    base = cap_n;
    sink_mode = 1;
    idle(8);
    chk("R8 write still completes", cap_n - base, 2);

    // R5 readback of 3
    wr(12'h108, 32'h3);
    wr(12'h10C, 32'h2);
    idle(10);
    rd(12'h118, d); chk("R5 occupancy 3", d, 32'h3);
    rd(12'h110, d); chk("R5 done after readback", d, 32'h121);
    for (int i = 0; i < 3; i++) begin
      rd(12'h104, d); chk("R5 readback word", d, nexp); nexp++;
    end
    rd(12'h104, d); chk("R6 empty read returns 0", d, 32'h0);
    rd(12'h118, d); chk("R6 occupancy stays 0", d, 32'h0);

    // R7 back-pressure: 6 words into 4-deep FIFO
    wr(12'h108, 32'h6);
    wr(12'h10C, 32'h2);
    idle(10);
    rd(12'h118, d); chk("R7 occupancy full", d, 32'h4);
    rd(12'h110, d); chk("R7 R11 status readback running", d, 32'h160);
    chk("R7 in_ready low when full", {31'b0, cfg_in_ready}, 32'h0);
    rd(12'h104, d); chk("R7 word", d, nexp); nexp++;
    rd(12'h118, d); chk("R12 occupancy after pop", d, 32'h3);
    rd(12'h104, d); chk("R7 word", d, nexp); nexp++;
    idle(10);
    rd(12'h110, d); chk("R7 done after resume", d, 32'h121);
    for (int i = 0; i < 4; i++) begin
      rd(12'h104, d); chk("R7 no loss word", d, nexp); nexp++;
    end

    // R5 size 0 does nothing
    wr(12'h108, 32'h0);
    wr(12'h10C, 32'h2);
    idle(4);
    rd(12'h110, d); chk("R5 size 0 stays done", d, 32'h121);
    rd(12'h118, d); chk("R5 size 0 no words", d, 32'h0);

    // R9 flush keeps size
    sink_mode = 0;
    for (int i = 0; i < 3; i++) wr(12'h100, 32'hD0 + i);
    wr(12'h108, 32'h2);
    wr(12'h10C, 32'h2);
    idle(8);
    nexp = nexp + 2;
    wr(12'h10C, 32'h4);
    rd(12'h114, d); chk("R9 vacancy after flush", d, 32'h8);
    rd(12'h118, d); chk("R9 occupancy after flush", d, 32'h0);
    rd(12'h108, d); chk("R9 size kept", d, 32'h2);

    // R10 soft reset during a stalled write
    wr(12'h100, 32'hE0);
    wr(12'h100, 32'hE1);
    wr(12'h10C, 32'h1);
    wr(12'h108, 32'h7);
    rd(12'h110, d); chk("R10 busy before reset", d, 32'h120);
    wr(12'h10C, 32'h8);
    rd(12'h110, d); chk("R10 status after soft reset", d, 32'h121);
    rd(12'h108, d); chk("R10 size cleared", d, 32'h0);
    rd(12'h114, d); chk("R10 vacancy restored", d, 32'h8);
    chk("R10 out_valid low", {31'b0, cfg_out_valid}, 32'h0);

    // R11 port condition pass-through
    cfg_err_n = 0; cfg_aligned = 1; cfg_abort_n = 0;
    idle(1);
    rd(12'h110, d); chk("R11 status inputs", d, 32'h081);
    rd(12'h120, d); chk("R2 unmapped reads 0", d, 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule